// File: doc/BRIEF.md
# Reshapeable 4-Kbit Embedded RAM

This block is a 4096-bit on-chip memory whose logical width and depth are chosen by configuration. A single physical array of 128 words by 32 bits is presented as 4096x1, 2048x2, 1024x4, 512x8, 256x16 or 128x32. In the narrow shapes the low address bits pick a slice of one physical word. A write changes only that slice and leaves the rest of the word as it was.

A mode input sets the port arrangement. The block can run as a read-only table, as a single-port RAM, or as a RAM with a separate read address. The table contents are placed through a word-wide load port, which works in every mode. Addresses, data and write enable are captured on the clock edge. The read result can come from an output register or straight from the array at the captured address.

Even parity is generated per byte on every write and stored beside the data. A mismatch in any byte that a read covers raises an error flag, but only in the shapes that are 8 bits or wider. A clock enable freezes the block. A synchronous output clear empties the output register and does not touch the stored data.

Top module: `reshape_ram`

## Requirements
- R1: `cfgWidth` code c (0..5) selects a width of 2^c bits. The word index is `addr >> (5-c)` and the slice bit offset is `(addr mod 2^(5-c)) * 2^c`. `rdData` carries the slice in its low 2^c bits, and its upper bits read zero.
- R2: A write in a narrow shape changes only the addressed slice of the physical word. All other bits of that word keep their values.
- R3: With `cfgSyncOut`=1, `rdData` changes only at a rising edge with `clkEn`=1. It then shows the slice at the read address presented at that edge.
- R4: With `cfgSyncOut`=0, `rdData` is taken combinationally from the read address captured at the last enabled edge. It shows a write made at that same edge directly after the edge.
- R5: With `cfgMode`=2 (separate read address), reads use `addrB` and writes use `addrA`. When both name the same location in the same cycle with `cfgSyncOut`=1, the read returns the previous contents.
- R6: With `cfgMode`=1 (single port), or with code 3, both reads and writes use `addrA`. A read during a write to that address with `cfgSyncOut`=1 returns the previous contents.
- R7: With `cfgMode`=0 (table), `wrEn` has no effect. In any mode, `loadEn`=1 at an edge stores `loadData` and `loadPar` at physical word `loadAddr`, whatever `clkEn` is. A user write in the same cycle is dropped.
- R8: With `clkEn`=0, no user write happens, the read address is not captured, and the registered output holds.
- R9: `outRst`=1 at an edge clears the registered `rdData` and `parErr` to 0. The stored contents are not changed.
- R10: A write stores even parity for each byte i, so the parity bit equals the XOR of the byte's bits, in parity bit i. `parErr` is 1 when any byte lying fully inside the read slice fails this check, for widths 8, 16 and 32. For widths below 8, `parErr` is 0. `loadPar` bit i is stored as given for byte i.
- R11: While `rstN` is low and directly after its release, the registered `rdData` and `parErr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low, for the output and address registers |
| cfgMode | input | 2 | 0 table, 1 single port, 2 separate read address, 3 as 1 |
| cfgWidth | input | 3 | Shape code: width is 2^code bits, codes above 5 act as 5 |
| cfgSyncOut | input | 1 | 1 registered read output, 0 unregistered |
| clkEn | input | 1 | Clock enable for user writes, address capture and the output register |
| wrEn | input | 1 | Write request at `addrA` |
| addrA | input | 12 | Write address, and read address outside mode 2 |
| dataIn | input | 32 | Write data, low bits used in narrow shapes |
| addrB | input | 12 | Read address in mode 2 |
| outRst | input | 1 | Synchronous clear of the registered output |
| loadEn | input | 1 | Load strobe for a whole physical word |
| loadAddr | input | 7 | Physical word index for a load |
| loadData | input | 32 | Word stored by a load |
| loadPar | input | 4 | Byte parity bits stored by a load |
| rdData | output | 32 | Read slice, zero-extended |
| parErr | output | 1 | Parity mismatch on the read slice |

## Verification
In registered mode a read result appears right after the enabled edge that captures the read address. A write made at edge k is seen by a read captured at edge k+1. In unregistered mode the data appear directly after the capturing edge and already include a write from that same edge. The bench changes inputs and compares outputs 1 ns after each rising edge, and for every check it counts exactly one edge from stimulus to result. A check for hold behaviour also samples before the edge to show that the output has not moved early.

// File: rtl/reshape_ram_pkg.sv
package reshape_ram_pkg;
  parameter int WORD_W     = 32;
  parameter int DEPTH      = 128;
  parameter int LANE_W     = 8;
  localparam int LANES     = WORD_W / LANE_W;
  localparam int WORD_IDX_W = $clog2(DEPTH);
  localparam int OFF_W     = $clog2(WORD_W);
  localparam int ADDR_W    = WORD_IDX_W + OFF_W;
  localparam int SHAPE_W   = 3;
  localparam int SHAPE_MAX = OFF_W;
  localparam int LANE_SHAPE = $clog2(LANE_W);

  typedef enum logic [1:0] {
    MODE_TABLE = 2'd0,
    MODE_SINGLE = 2'd1,
    MODE_DUAL  = 2'd2,
    MODE_ALT   = 2'd3
  } ramMode_e;

  typedef struct packed {
    logic                  wrStrobe;
    logic                  ldStrobe;
    logic                  capStrobe;
    logic                  clrStrobe;
    logic                  syncOut;
    logic [SHAPE_W-1:0]    shape;
    logic [WORD_IDX_W-1:0] wrWord;
    logic [OFF_W-1:0]      wrOff;
    logic [WORD_IDX_W-1:0] rdWord;
    logic [OFF_W-1:0]      rdOff;
    logic [WORD_IDX_W-1:0] ldWord;
  } ramStrobes_t;

  typedef struct packed {
    logic [WORD_W-1:0] data;
    logic              err;
  } readRes_t;

  function automatic logic [WORD_IDX_W-1:0] wordOf(input logic [ADDR_W-1:0] a,
                                                   input logic [SHAPE_W-1:0] s);
    logic [ADDR_W-1:0] t;
    t = a >> (OFF_W - int'(s));
    return t[WORD_IDX_W-1:0];
  endfunction

  function automatic logic [OFF_W-1:0] offOf(input logic [ADDR_W-1:0] a,
                                             input logic [SHAPE_W-1:0] s);
    logic [ADDR_W-1:0] msk;
    logic [ADDR_W-1:0] t;
    msk = (ADDR_W'(1) << (OFF_W - int'(s))) - ADDR_W'(1);
    t   = (a & msk) << s;
    return t[OFF_W-1:0];
  endfunction

  function automatic logic [WORD_W-1:0] widthMask(input logic [SHAPE_W-1:0] s);
    if (int'(s) >= SHAPE_MAX) return '1;
    return (WORD_W'(1) << (1 << int'(s))) - WORD_W'(1);
  endfunction
endpackage

// File: rtl/reshape_ram_ctrl.sv
module reshape_ram_ctrl
  import reshape_ram_pkg::*;
(
  input  logic [1:0]            cfgMode,
  input  logic [SHAPE_W-1:0]    cfgWidth,
  input  logic                  cfgSyncOut,
  input  logic                  clkEn,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     addrA,
  input  logic [ADDR_W-1:0]     addrB,
  input  logic                  outRst,
  input  logic                  loadEn,
  input  logic [WORD_IDX_W-1:0] loadAddr,
  output ramStrobes_t           st
);
  logic [SHAPE_W-1:0] shapeEff;
  logic [ADDR_W-1:0]  rdAddr;
  logic               writable;

  always_comb begin
    shapeEff = (int'(cfgWidth) > SHAPE_MAX) ? SHAPE_W'(SHAPE_MAX) : cfgWidth;
    rdAddr   = (ramMode_e'(cfgMode) == MODE_DUAL) ? addrB : addrA;
    writable = (ramMode_e'(cfgMode) != MODE_TABLE);

    st.wrStrobe  = clkEn & wrEn & writable;
    st.ldStrobe  = loadEn;
    st.capStrobe = clkEn;
    st.clrStrobe = outRst;
    st.syncOut   = cfgSyncOut;
    st.shape     = shapeEff;
    st.wrWord    = wordOf(addrA, shapeEff);
    st.wrOff     = offOf(addrA, shapeEff);
    st.rdWord    = wordOf(rdAddr, shapeEff);
    st.rdOff     = offOf(rdAddr, shapeEff);
    st.ldWord    = loadAddr;
  end
endmodule

// File: rtl/reshape_ram_dp.sv
module reshape_ram_dp
  import reshape_ram_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ramStrobes_t       st,
  input  logic [WORD_W-1:0] dataIn,
  input  logic [WORD_W-1:0] loadData,
  input  logic [LANES-1:0]  loadPar,
  output logic [WORD_W-1:0] rdData,
  output logic              parErr
);
  logic [WORD_W-1:0] mem    [DEPTH];
  logic [LANES-1:0]  parMem [DEPTH];

  logic [WORD_W-1:0]     wMask, wrMask, oldWord, newWord;
  logic [LANES-1:0]      newPar;
  logic [WORD_IDX_W-1:0] rdWordQ;
  logic [OFF_W-1:0]      rdOffQ;
  logic [WORD_W-1:0]     outQ;
  logic                  errQ;
  readRes_t              rdNow, rdHeld;

  function automatic readRes_t readSlice(input logic [WORD_W-1:0] w,
                                         input logic [LANES-1:0] p,
                                         input logic [OFF_W-1:0] off,
                                         input logic [SHAPE_W-1:0] sh);
    readRes_t r;
    int width;
    width  = 1 << int'(sh);
    r.data = (w >> off) & widthMask(sh);
    r.err  = 1'b0;
    for (int l = 0; l < LANES; l++) begin
      if (int'(sh) >= LANE_SHAPE && l * LANE_W >= int'(off) &&
          l * LANE_W < int'(off) + width &&
          (^w[l*LANE_W +: LANE_W]) != p[l])
        r.err = 1'b1;
    end
    return r;
  endfunction

  // merge the write slice into the stored word and regenerate byte parity
  always_comb begin
    wMask   = widthMask(st.shape);
    wrMask  = wMask << st.wrOff;
    oldWord = mem[st.wrWord];
    newWord = (oldWord & ~wrMask) | ((dataIn << st.wrOff) & wrMask);
    for (int l = 0; l < LANES; l++)
      newPar[l] = ^newWord[l*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (st.ldStrobe) begin
      mem[st.ldWord]    <= loadData;
      parMem[st.ldWord] <= loadPar;
    end else if (st.wrStrobe) begin
      mem[st.wrWord]    <= newWord;
      parMem[st.wrWord] <= newPar;
    end
  end

  always_comb begin
    rdNow  = readSlice(mem[st.rdWord], parMem[st.rdWord], st.rdOff, st.shape);
    rdHeld = readSlice(mem[rdWordQ], parMem[rdWordQ], rdOffQ, st.shape);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdWordQ <= '0;
      rdOffQ  <= '0;
      outQ    <= '0;
      errQ    <= 1'b0;
    end else begin
      if (st.capStrobe) begin
        rdWordQ <= st.rdWord;
        rdOffQ  <= st.rdOff;
      end
      if (st.clrStrobe) begin
        outQ <= '0;
        errQ <= 1'b0;
      end else if (st.capStrobe) begin
        outQ <= rdNow.data;
        errQ <= rdNow.err;
      end
    end
  end

  assign rdData = st.syncOut ? outQ : rdHeld.data;
  assign parErr = st.syncOut ? errQ : rdHeld.err;

  // R2: bits outside the written slice survive the write
  assert_slice_kept_R2: assert property (@(posedge clk) disable iff (!rstN)
    (st.wrStrobe && !st.ldStrobe) |=>
      ((mem[$past(st.wrWord)] & ~$past(wrMask)) == ($past(oldWord) & ~$past(wrMask))));

  // R8: with the enable low and no clear, output and captured address stay
  assert_hold_when_disabled_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!st.capStrobe && !st.clrStrobe) |=> ($stable(outQ) && $stable(rdWordQ)));

  // R9: the output clear empties data and error flag on the next edge
  assert_out_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    st.clrStrobe |=> (outQ == '0 && !errQ));

  // R10: narrow shapes never report a parity error
  assert_no_err_narrow_R10: assert property (@(posedge clk) disable iff (!rstN)
    (st.capStrobe && !st.clrStrobe && int'(st.shape) < LANE_SHAPE) |=> !errQ);
endmodule

// File: rtl/reshape_ram.sv
module reshape_ram
  import reshape_ram_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [1:0]            cfgMode,
  input  logic [SHAPE_W-1:0]    cfgWidth,
  input  logic                  cfgSyncOut,
  input  logic                  clkEn,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     addrA,
  input  logic [WORD_W-1:0]     dataIn,
  input  logic [ADDR_W-1:0]     addrB,
  input  logic                  outRst,
  input  logic                  loadEn,
  input  logic [WORD_IDX_W-1:0] loadAddr,
  input  logic [WORD_W-1:0]     loadData,
  input  logic [LANES-1:0]      loadPar,
  output logic [WORD_W-1:0]     rdData,
  output logic                  parErr
);
  ramStrobes_t st;

  reshape_ram_ctrl i_ctrl (
    .cfgMode(cfgMode), .cfgWidth(cfgWidth), .cfgSyncOut(cfgSyncOut),
    .clkEn(clkEn), .wrEn(wrEn), .addrA(addrA), .addrB(addrB),
    .outRst(outRst), .loadEn(loadEn), .loadAddr(loadAddr), .st(st)
  );

  reshape_ram_dp i_dp (
    .clk(clk), .rstN(rstN), .st(st), .dataIn(dataIn),
    .loadData(loadData), .loadPar(loadPar), .rdData(rdData), .parErr(parErr)
  );
endmodule

// File: tb/test_reshape_ram.sv
module test_reshape_ram;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  cfgMode = 2'd2;
  logic [2:0]  cfgWidth = 3'd5;
  logic        cfgSyncOut = 1'b1;
  logic        clkEn = 1'b0;
  logic        wrEn = 1'b0;
  logic [11:0] addrA = '0;
  logic [31:0] dataIn = '0;
  logic [11:0] addrB = '0;
  logic        outRst = 1'b0;
  logic        loadEn = 1'b0;
  logic [6:0]  loadAddr = '0;
  logic [31:0] loadData = '0;
  logic [3:0]  loadPar = '0;
  logic [31:0] rdData;
  logic        parErr;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  reshape_ram i_reshape_ram (
    .clk(clk), .rstN(rstN), .cfgMode(cfgMode), .cfgWidth(cfgWidth),
    .cfgSyncOut(cfgSyncOut), .clkEn(clkEn), .wrEn(wrEn), .addrA(addrA),
    .dataIn(dataIn), .addrB(addrB), .outRst(outRst), .loadEn(loadEn),
    .loadAddr(loadAddr), .loadData(loadData), .loadPar(loadPar),
    .rdData(rdData), .parErr(parErr)
  );

  function automatic logic [31:0] pat(input int a, input int s);
    return (32'(a) * 32'h9E3779B1) ^ (32'(s) << 27) ^ (32'(a) << 5);
  endfunction

  function automatic logic [31:0] maskOf(input int s);
    return (s >= 5) ? 32'hFFFF_FFFF : ((32'd1 << (1 << s)) - 32'd1);
  endfunction

  function automatic logic [3:0] evenPar(input logic [31:0] w);
    return {^w[31:24], ^w[23:16], ^w[15:8], ^w[7:0]};
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    nFails++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    // R11: reset state of the registered output
    step(); step();
    chk("R11 rdData in reset", rdData, 32'h0);
    chk("R11 parErr in reset", {31'd0, parErr}, 32'h0);
    rstN = 1'b1;
    step();
    chk("R11 rdData after release", rdData, 32'h0);

    // R1/R2/R5/R10: sweep every shape, write all addresses then read all back
    clkEn = 1'b1;
    for (int s = 0; s < 6; s++) begin
      cfgWidth = 3'(s);
      for (int a = 0; a < (4096 >> s); a++) begin
        wrEn = 1'b1; addrA = 12'(a); dataIn = pat(a, s);
        step();
      end
      wrEn = 1'b0;
      for (int a = 0; a < (4096 >> s); a++) begin
        addrB = 12'(a);
        step();
        chk("R1 sweep read", rdData, pat(a, s) & maskOf(s));
        chk("R10 sweep parity clean", {31'd0, parErr}, 32'h0);
      end
    end
    // now word w holds pat(w,5)

    // R3: registered output moves only at the edge
    cfgWidth = 3'd5; addrB = 12'd20;
    step();
    chk("R3 read word 20", rdData, pat(20, 5));
    addrB = 12'd21;
    #1;
    chk("R3 no change before edge", rdData, pat(20, 5));
    step();
    chk("R3 read word 21", rdData, pat(21, 5));

    // R2: narrow write touches only its slice (x2, word 10 slice 3)
    cfgWidth = 3'd1; addrA = 12'(10 * 16 + 3); dataIn = 32'h2; wrEn = 1'b1;
    step();
    wrEn = 1'b0; cfgWidth = 3'd5; addrB = 12'd10;
    step();
    chk("R2 slice merge", rdData, (pat(10, 5) & ~(32'h3 << 6)) | (32'h2 << 6));

    // R4: unregistered output shows a same-edge write
    cfgSyncOut = 1'b0; cfgWidth = 3'd3; addrB = 12'd100;
    step();
    chk("R4 async read", rdData, pat(25, 5) & 32'hFF);
    wrEn = 1'b1; addrA = 12'd100; dataIn = 32'h5A;
    step();
    wrEn = 1'b0;
    chk("R4 async write-through", rdData, 32'h5A);
    cfgSyncOut = 1'b1;

    // R6: single port read during write returns old data
    cfgMode = 2'd1; cfgWidth = 3'd5; addrA = 12'd7; dataIn = 32'hCAFE0007; wrEn = 1'b1;
    step();
    chk("R6 old data on write", rdData, pat(7, 5));
    wrEn = 1'b0;
    step();
    chk("R6 new data after", rdData, 32'hCAFE0007);

    // R5: dual port same address returns old data
    cfgMode = 2'd2; addrA = 12'd8; addrB = 12'd8; dataIn = 32'h12345678; wrEn = 1'b1;
    step();
    chk("R5 same-address old", rdData, pat(8, 5));
    wrEn = 1'b0;
    step();
    chk("R5 same-address new", rdData, 32'h12345678);

    // R7: table mode ignores writes, load port stores the word
    cfgMode = 2'd0; clkEn = 1'b0;
    loadEn = 1'b1; loadAddr = 7'd9; loadData = 32'hA5A50F0F; loadPar = evenPar(32'hA5A50F0F);
    step();
    loadEn = 1'b0; clkEn = 1'b1; wrEn = 1'b1; addrA = 12'd9; dataIn = 32'hFFFF_FFFF;
    step();
    wrEn = 1'b0;
    step();
    chk("R7 table ignores write", rdData, 32'hA5A50F0F);
    chk("R7 loaded parity ok", {31'd0, parErr}, 32'h0);
    // R7: load beats a user write in the same cycle
    cfgMode = 2'd1; loadEn = 1'b1; loadAddr = 7'd3; loadData = 32'h0BAD_F00D;
    loadPar = evenPar(32'h0BAD_F00D); wrEn = 1'b1; addrA = 12'd3; dataIn = 32'h1111_2222;
    step();
    loadEn = 1'b0; wrEn = 1'b0;
    step();
    chk("R7 load priority", rdData, 32'h0BAD_F00D);

    // R8: clock enable low freezes everything
    cfgMode = 2'd2; addrB = 12'd11;
    step();
    chk("R8 setup read", rdData, pat(11, 5));
    clkEn = 1'b0; addrB = 12'd12; wrEn = 1'b1; addrA = 12'd11; dataIn = 32'h0;
    step();
    chk("R8 output held", rdData, pat(11, 5));
    clkEn = 1'b1; wrEn = 1'b0; addrB = 12'd11;
    step();
    chk("R8 no write while disabled", rdData, pat(11, 5));

    // R9: output clear keeps contents
    outRst = 1'b1;
    step();
    chk("R9 cleared data", rdData, 32'h0);
    chk("R9 cleared flag", {31'd0, parErr}, 32'h0);
    outRst = 1'b0;
    step();
    chk("R9 contents kept", rdData, pat(11, 5));

    // R10: injected parity fault in byte 0 of word 5
    loadEn = 1'b1; loadAddr = 7'd5; loadData = 32'h1; loadPar = 4'b0000;
    step();
    loadEn = 1'b0; cfgWidth = 3'd3; addrB = 12'd20;
    step();
    chk("R10 x8 bad byte data", rdData, 32'h1);
    chk("R10 x8 bad byte flag", {31'd0, parErr}, 32'h1);
    addrB = 12'd21;
    step();
    chk("R10 x8 good byte flag", {31'd0, parErr}, 32'h0);
    cfgWidth = 3'd4; addrB = 12'd10;
    step();
    chk("R10 x16 flag", {31'd0, parErr}, 32'h1);
    cfgWidth = 3'd2; addrB = 12'd40;
    step();
    chk("R10 x4 data", rdData, 32'h1);
    chk("R10 x4 no flag", {31'd0, parErr}, 32'h0);
    cfgWidth = 3'd5; addrB = 12'd5;
    step();
    chk("R10 x32 flag", {31'd0, parErr}, 32'h1);
    // R1: shape code above 5 acts as 32-bit
    cfgWidth = 3'd7; addrB = 12'd21;
    step();
    chk("R1 code 7 as x32", rdData, pat(21, 5));

    summary();
  end
endmodule